// File: doc/BRIEF.md
# Redundant Load Replay Queue

This block sits between two redundant copies of one program, a leading copy and a trailing copy. Each time a load retires in the leading copy, the block stores the load address and the loaded value. The trailing copy does not access the data cache. Each of its loads takes the oldest stored entry and presents its own address with the request. The block returns the stored value and compares the two addresses. If the addresses differ, the two copies have diverged, and the block raises a fault. The trailing copy always receives the value the leading copy saw, so writes that reach memory between the two loads cannot make the copies diverge.

The stored entries lie outside the redundant computation. Each entry is therefore kept as a SECDED codeword over the address and data together. A single flipped bit is repaired on the read path before the address is compared and the data is returned. A double flip is reported on its own output. The retire side sees backpressure when every slot is occupied. A trailing request to an empty queue gets a not-valid response and consumes nothing. A test input can flip chosen stored payload bits at write time, so the code can be exercised from the ports.

Top module: `ldrep_queue`

## Requirements
- R1: After reset the queue is empty, `lead_rdy_o` is 1, `fault_sticky_o` is 0, and a trailing request gets `trail_vld_o` = 0.
- R2: An entry is written on a rising edge where `lead_vld_i` and `lead_rdy_o` are both 1. `lead_rdy_o` is 0 exactly while DEPTH entries are held. A retire offered while `lead_rdy_o` is 0 is dropped.
- R3: Trailing reads return the stored load data in the order of writing, oldest first.
- R4: When `trail_req_i` is 1 and the queue is not empty, `trail_vld_o` is 1 in the same cycle and the oldest entry is removed at the next edge. When the queue is empty, `trail_vld_o` stays 0 and nothing is removed.
- R5: On a valid trailing read whose `trail_addr_i` differs from the stored (corrected) address, `addr_fault_o` is 1 for that cycle only. The entry is still consumed and its data is still returned.
- R6: `fault_sticky_o` becomes 1 in the cycle after any cycle with `addr_fault_o` or `ecc_uncorr_o` at 1. It stays 1 until `rst_ni` is asserted.
- R7: If exactly one stored payload bit is flipped, the read returns the original address and data, with no address fault when the addresses match, and `ecc_corr_o` pulses for that cycle.
- R8: If two stored payload bits are flipped, `ecc_uncorr_o` pulses on that read and `addr_fault_o` stays 0 for that read.
- R9: A write and a read in the same cycle both take effect when the queue is neither full nor empty, and the entry count is then unchanged.
- R10: Bit i of `inj_mask_i` flips bit i of the payload {address, data} as stored by the write in that cycle. Bits DW-1:0 cover the data and bits AW+DW-1:DW cover the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lead_vld_i | input | 1 | Leading load retiring |
| lead_rdy_o | output | 1 | Free slot available |
| lead_addr_i | input | AW | Leading load address |
| lead_data_i | input | DW | Leading load value |
| inj_mask_i | input | AW+DW | Payload bits to flip at write (test) |
| trail_req_i | input | 1 | Trailing load requests its value |
| trail_addr_i | input | AW | Trailing load address |
| trail_vld_o | output | 1 | Value returned this cycle |
| trail_data_o | output | DW | Returned load value |
| addr_fault_o | output | 1 | Address mismatch pulse |
| ecc_corr_o | output | 1 | Single-bit error repaired pulse |
| ecc_uncorr_o | output | 1 | Double-bit error pulse |
| fault_sticky_o | output | 1 | Latched error flag |

## Verification
The hardest situation to reach is a corrupted stored entry. The codeword is never visible at the ports, and a flip anywhere else would just be written as a new, valid codeword. The stimulus uses the write-time flip mask to place single flips in the address and data fields and double flips across them. It then reads those entries with matching addresses, so that only the code logic can account for any fault seen. The full and empty edges are approached with overlapping writes and reads, so wrap-around and same-cycle traffic are covered as well.

// File: rtl/lvq_pkg.sv
package lvq_pkg;

  typedef enum logic [1:0] {
    ECC_CLEAN = 2'd0,
    ECC_FIXED = 2'd1,
    ECC_BAD   = 2'd2
  } ecc_stat_e;

  // Hamming check bits needed for k payload bits
  function automatic int unsigned secded_r(int unsigned k);
    int unsigned r;
    r = 1;
    while ((1 << r) < (k + r + 1)) r++;
    return r;
  endfunction

endpackage

// File: rtl/lvq_secded_enc.sv
module lvq_secded_enc
  import lvq_pkg::*;
#(
  parameter  int unsigned K = 96,
  localparam int unsigned R = secded_r(K),
  localparam int unsigned N = K + R + 1
) (
  input  logic [K-1:0] data_i,
  output logic [N-1:0] code_o
);

  logic [N-1:0] h;
  logic [R-1:0] chk;
  int j;

  // systematic layout: {overall, check, payload}
  always_comb begin
    h = '0;
    j = 0;
    for (int p = 1; p < N; p++) begin
      if ((p & (p - 1)) != 0) begin
        h[p] = data_i[j];
        j = j + 1;
      end
    end
    for (int i = 0; i < R; i++) begin
      chk[i] = 1'b0;
      for (int p = 1; p < N; p++) begin
        if (((p >> i) & 1) != 0) chk[i] = chk[i] ^ h[p];
      end
    end
    code_o = {^{chk, data_i}, chk, data_i};
  end

endmodule

// File: rtl/lvq_secded_dec.sv
module lvq_secded_dec
  import lvq_pkg::*;
#(
  parameter  int unsigned K = 96,
  localparam int unsigned R = secded_r(K),
  localparam int unsigned N = K + R + 1
) (
  input  logic [N-1:0] code_i,
  output logic [K-1:0] data_o,
  output ecc_stat_e    stat_o
);

  logic [N-1:0] h;
  logic [R-1:0] syn;
  logic         ovp;
  int j;
  int k;

  always_comb begin
    h = '0;
    j = 0;
    k = 0;
    for (int p = 1; p < N; p++) begin
      if ((p & (p - 1)) != 0) begin
        h[p] = code_i[j];
        j = j + 1;
      end else begin
        h[p] = code_i[K + k];
        k = k + 1;
      end
    end
    for (int i = 0; i < R; i++) begin
      syn[i] = 1'b0;
      for (int p = 1; p < N; p++) begin
        if (((p >> i) & 1) != 0) syn[i] = syn[i] ^ h[p];
      end
    end
    ovp = ^code_i;
    // odd overall parity: single error at position syn (0 = overall bit)
    if (ovp) begin
      for (int p = 1; p < N; p++) begin
        if (p == int'(syn)) h[p] = ~h[p];
      end
    end
    if (!ovp && syn == '0) stat_o = ECC_CLEAN;
    else if (ovp)          stat_o = ECC_FIXED;
    else                   stat_o = ECC_BAD;
    data_o = '0;
    j = 0;
    for (int p = 1; p < N; p++) begin
      if ((p & (p - 1)) != 0) begin
        data_o[j] = h[p];
        j = j + 1;
      end
    end
  end

endmodule

// File: rtl/lvq_ring.sv
module lvq_ring #(
  parameter  int unsigned DEPTH = 16,
  parameter  int unsigned W     = 104,
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [W-1:0]    wdata_i,
  input  logic            pop_i,
  output logic [W-1:0]    rdata_o,
  output logic            full_o,
  output logic            empty_o,
  output logic [CNTW-1:0] cnt_o
);

  logic [W-1:0]    mem_q [DEPTH];
  logic [PW-1:0]   wr_q, rd_q;
  logic [CNTW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] ptr);
    return (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_q];
  assign full_o  = (cnt_q == CNTW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/ldrep_queue.sv
module ldrep_queue
  import lvq_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 64,
  parameter int unsigned DEPTH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lead_vld_i,
  output logic               lead_rdy_o,
  input  logic [AW-1:0]      lead_addr_i,
  input  logic [DW-1:0]      lead_data_i,
  input  logic [AW+DW-1:0]   inj_mask_i,
  input  logic               trail_req_i,
  input  logic [AW-1:0]      trail_addr_i,
  output logic               trail_vld_o,
  output logic [DW-1:0]      trail_data_o,
  output logic               addr_fault_o,
  output logic               ecc_corr_o,
  output logic               ecc_uncorr_o,
  output logic               fault_sticky_o
);

  localparam int unsigned PLW  = AW + DW;
  localparam int unsigned R    = secded_r(PLW);
  localparam int unsigned CW   = PLW + R + 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  logic [CW-1:0]   enc_w, store_w, head_w;
  logic [PLW-1:0]  dec_w;
  ecc_stat_e       stat_w;
  logic            full_w, empty_w, push_w, pop_w;
  logic [CNTW-1:0] cnt_w;
  logic            sticky_q;

  lvq_secded_enc #(.K(PLW)) i_enc (
    .data_i ({lead_addr_i, lead_data_i}),
    .code_o (enc_w)
  );

  // payload sits in the low bits of the systematic codeword
  assign store_w = enc_w ^ {{(R + 1){1'b0}}, inj_mask_i};

  assign push_w = lead_vld_i && !full_w;
  assign pop_w  = trail_req_i && !empty_w;

  lvq_ring #(.DEPTH(DEPTH), .W(CW)) i_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_w),
    .wdata_i (store_w),
    .pop_i   (pop_w),
    .rdata_o (head_w),
    .full_o  (full_w),
    .empty_o (empty_w),
    .cnt_o   (cnt_w)
  );

  lvq_secded_dec #(.K(PLW)) i_dec (
    .code_i (head_w),
    .data_o (dec_w),
    .stat_o (stat_w)
  );

  assign lead_rdy_o   = !full_w;
  assign trail_vld_o  = pop_w;
  assign trail_data_o = dec_w[DW-1:0];
  // a double error leaves the address untrustworthy: no compare
  assign addr_fault_o = pop_w && (stat_w != ECC_BAD) && (dec_w[PLW-1:DW] != trail_addr_i);
  assign ecc_corr_o   = pop_w && (stat_w == ECC_FIXED);
  assign ecc_uncorr_o = pop_w && (stat_w == ECC_BAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= 1'b0;
    else         sticky_q <= sticky_q | addr_fault_o | ecc_uncorr_o;
  end

  assign fault_sticky_o = sticky_q;

endmodule

// File: rtl/ldrep_queue_chk.sv
module ldrep_queue_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNTW  = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lead_vld_i,
  input logic            lead_rdy_o,
  input logic            trail_req_i,
  input logic            trail_vld_o,
  input logic            addr_fault_o,
  input logic            ecc_corr_o,
  input logic            ecc_uncorr_o,
  input logic            fault_sticky_o,
  input logic [CNTW-1:0] cnt_i
);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNTW'(DEPTH)); // R2
  AST_PUSH_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_vld_i && lead_rdy_o && !trail_vld_o) |=> cnt_i == $past(cnt_i) + 1'b1); // R2
  AST_POP_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trail_vld_o && !(lead_vld_i && lead_rdy_o)) |=> cnt_i == $past(cnt_i) - 1'b1); // R4
  AST_BOTH_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trail_vld_o && lead_vld_i && lead_rdy_o) |=> $stable(cnt_i)); // R9
  AST_EMPTY_NO_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |-> !trail_vld_o); // R4
  AST_VLD_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_vld_o |-> trail_req_i); // R4
  AST_FAULT_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_fault_o |-> trail_vld_o); // R5
  AST_STICKY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_fault_o || ecc_uncorr_o) |=> fault_sticky_o); // R6
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_sticky_o |=> fault_sticky_o); // R6
  AST_ECC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ecc_corr_o && ecc_uncorr_o)); // R7
  AST_UNCORR_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_uncorr_o |-> !addr_fault_o); // R8

endmodule

bind ldrep_queue ldrep_queue_chk #(.DEPTH(DEPTH), .CNTW(CNTW)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lead_vld_i     (lead_vld_i),
  .lead_rdy_o     (lead_rdy_o),
  .trail_req_i    (trail_req_i),
  .trail_vld_o    (trail_vld_o),
  .addr_fault_o   (addr_fault_o),
  .ecc_corr_o     (ecc_corr_o),
  .ecc_uncorr_o   (ecc_uncorr_o),
  .fault_sticky_o (fault_sticky_o),
  .cnt_i          (cnt_w)
);

// File: tb/test_ldrep_queue.sv
`timescale 1ns/1ps
module test_ldrep_queue;

  localparam int AW = 32;
  localparam int DW = 64;
  localparam int DEPTH = 16;
  localparam int PLW = AW + DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lead_vld = 1'b0;
  logic [AW-1:0] lead_addr = '0;
  logic [DW-1:0] lead_data = '0;
  logic [PLW-1:0] inj_mask = '0;
  logic trail_req = 1'b0;
  logic [AW-1:0] trail_addr = '0;
  logic lead_rdy, trail_vld, addr_fault, ecc_corr, ecc_uncorr, fault_sticky;
  logic [DW-1:0] trail_data;

  always #2.5 clk = ~clk;

  ldrep_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) i_ldrep_queue (
    .clk_i(clk), .rst_ni(rst_n),
    .lead_vld_i(lead_vld), .lead_rdy_o(lead_rdy),
    .lead_addr_i(lead_addr), .lead_data_i(lead_data), .inj_mask_i(inj_mask),
    .trail_req_i(trail_req), .trail_addr_i(trail_addr),
    .trail_vld_o(trail_vld), .trail_data_o(trail_data),
    .addr_fault_o(addr_fault), .ecc_corr_o(ecc_corr), .ecc_uncorr_o(ecc_uncorr),
    .fault_sticky_o(fault_sticky)
  );

  typedef struct {
    logic [AW-1:0]  a;
    logic [DW-1:0]  d;
    logic [PLW-1:0] m;
  } ent_t;

  ent_t q[$];
  logic m_sticky = 1'b0;
  int checks = 0;
  int fails = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lead_vld = 1'b0;
    trail_req = 1'b0;
    inj_mask = '0;
    q.delete();
    m_sticky = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 lead_rdy after reset", DW'(lead_rdy), 64'd1);
    chk("R1 sticky after reset", DW'(fault_sticky), 64'd0);
  endtask

  // one clock: drive, compare with model, advance model
  task automatic cycle(input logic lv, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                       input logic [PLW-1:0] m, input logic tr, input logic [AW-1:0] ta);
    logic exp_rdy, pop, push, f, c, u;
    int errs;
    @(negedge clk);
    lead_vld = lv; lead_addr = la; lead_data = ld; inj_mask = m;
    trail_req = tr; trail_addr = ta;
    #1;
    exp_rdy = (q.size() < DEPTH);
    push = lv && exp_rdy;
    pop = tr && (q.size() > 0);
    f = 1'b0; c = 1'b0; u = 1'b0;
    chk("R2 lead_rdy", DW'(lead_rdy), DW'(exp_rdy));
    chk("R4 trail_vld", DW'(trail_vld), DW'(pop));
    chk("R6 sticky", DW'(fault_sticky), DW'(m_sticky));
    if (pop) begin
      errs = $countones(q[0].m);
      if (errs <= 1) begin
        chk("R3 trail_data", trail_data, q[0].d);
        f = (q[0].a != ta);
        c = (errs == 1);
      end else begin
        u = 1'b1;
      end
    end
    chk("R5 addr_fault", DW'(addr_fault), DW'(f));
    chk("R7 ecc_corr", DW'(ecc_corr), DW'(c));
    chk("R8 ecc_uncorr", DW'(ecc_uncorr), DW'(u));
    @(posedge clk);
    if (pop) begin
      void'(q.pop_front());
      if (f || u) m_sticky = 1'b1;
    end
    if (push) q.push_back('{a: la, d: ld, m: m});
  endtask

  function automatic logic [AW-1:0] head_addr();
    return (q.size() > 0) ? q[0].a : '0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1: read of empty queue right after reset
    cycle(1'b0, '0, '0, '0, 1'b1, 32'h0);

    // R2: fill past capacity, extra retires dropped
    for (int i = 0; i < DEPTH + 3; i++)
      cycle(1'b1, 32'h1000 + i, {32'hA5A50000, 32'(i)}, '0, 1'b0, '0);
    // R3 R4: drain in order, then read empty
    for (int i = 0; i < DEPTH + 2; i++)
      cycle(1'b0, '0, '0, '0, 1'b1, head_addr());

    // R9: steady simultaneous traffic at a partial fill level
    for (int i = 0; i < 4; i++)
      cycle(1'b1, 32'h2000 + i, 64'hFEED_0000 + i, '0, 1'b0, '0);
    for (int i = 0; i < 20; i++)
      cycle(1'b1, 32'h3000 + i, {32'(i), 32'hC0DE}, '0, 1'b1, head_addr());
    // full and read together: write dropped, read served
    for (int i = 0; i < DEPTH; i++)
      cycle(1'b1, 32'h4000 + i, 64'(i), '0, 1'b0, '0);
    cycle(1'b1, 32'h4999, 64'h9, '0, 1'b1, head_addr());
    cycle(1'b1, 32'h4aaa, 64'ha, '0, 1'b1, head_addr());
    for (int i = 0; i < DEPTH + 1; i++)
      cycle(1'b0, '0, '0, '0, 1'b1, head_addr());

    // R10 R7: single flips in data and address fields, sticky stays low
    do_reset();
    for (int b = 0; b < PLW; b += 7)
      cycle(1'b1, 32'h5000 + b, 64'h0123_4567_89AB_CDEF ^ 64'(b), PLW'(1) << b, 1'b0, '0);
    cycle(1'b1, 32'h5FFF, 64'h1, PLW'(1) << (PLW - 1), 1'b0, '0);
    for (int i = 0; i < DEPTH + 1; i++)
      cycle(1'b0, '0, '0, '0, 1'b1, head_addr());

    // R5 R6: mismatch pulse then sticky
    cycle(1'b1, 32'h6000, 64'h66, '0, 1'b0, '0);
    cycle(1'b1, 32'h6004, 64'h67, '0, 1'b0, '0);
    cycle(1'b0, '0, '0, '0, 1'b1, 32'h6001);
    cycle(1'b0, '0, '0, '0, 1'b1, head_addr());
    cycle(1'b0, '0, '0, '0, 1'b0, '0);

    // R6: reset clears sticky; R8: double flips set it again
    do_reset();
    cycle(1'b1, 32'h7000, 64'h77, (PLW'(1) << 3) | (PLW'(1) << 70), 1'b0, '0);
    cycle(1'b1, 32'h7004, 64'h78, (PLW'(1) << 0) | (PLW'(1) << 1), 1'b0, '0);
    cycle(1'b1, 32'h7008, 64'h79, '0, 1'b0, '0);
    for (int i = 0; i < 4; i++)
      cycle(1'b0, '0, '0, '0, 1'b1, head_addr());

    // mixed random traffic with occasional mismatches and flips
    do_reset();
    for (int i = 0; i < 600; i++) begin
      logic [PLW-1:0] m;
      int sel;
      sel = $urandom_range(0, 15);
      m = '0;
      if (sel == 0) m = PLW'(1) << $urandom_range(0, PLW - 1);
      cycle($urandom_range(0, 2) != 0, $urandom, {$urandom, $urandom}, m,
            $urandom_range(0, 2) != 0,
            ($urandom_range(0, 9) == 0) ? 32'($urandom) : head_addr());
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule